// File: doc/BRIEF.md
# Wiper Save/Restore Sequencer

This block moves a potentiometer wiper setting between the working wiper register, which lives outside it, and a small modeled nonvolatile store. It accepts decoded commands from a serial front end: restore the wiper from the store, save the present wiper into the store, or write a data word into any store slot. Programming the store is slow. It takes a parameterized number of cycles, during which the front end is locked and the ready flag is low. Reading the store for a restore uses a separate, shorter delay.

Out of reset, the block first reloads the wiper from store slot 0 and only then accepts commands. A hardware preset pin forces the wiper to midscale for as long as it is held low. On release, the wiper is reloaded from the store. A write-protect pin blocks both kinds of save but leaves restores and the preset pin working. A command that arrives while the block is busy is dropped, and a sticky error flag records this.

The store is a plain register array. Its factory contents are midscale in every slot, and reset returns it to that state.

Top module: `nv_wiper_keeper`

## Requirements
- R1: After reset, `rdy` is 0 and `lock` is 1. Exactly LOAD_CYCLES clock cycles after reset is released, `rdy` rises, and `restore_load` pulses for one cycle with `restore_val` equal to store slot 0.
- R2: Directly after reset, every store slot holds midscale, 2^(WIPER_W-1) (512 with the default width).
- R3: A save-wiper command (`cmd_op` = 2'b10) with `wp_n` high drops `rdy` for exactly SAVE_CYCLES cycles. Slot 0 then holds the `wiper_now` value sampled with the command, and no restore strobe is produced.
- R4: A save-word command (`cmd_op` = 2'b11) with `wp_n` high writes `cmd_data` into the slot selected by `cmd_addr`, with the same SAVE_CYCLES busy time. Other slots are left unchanged.
- R5: A restore command (`cmd_op` = 2'b01) drops `rdy` for exactly LOAD_CYCLES cycles. `restore_load` then pulses for one cycle with slot 0 on `restore_val`, in the same cycle that `rdy` returns high.
- R6: A command strobe seen while `rdy` is low, or while `preset_n` is low, is dropped without any effect on the store. It sets `drop_err`, which stays set until reset.
- R7: In every cycle after a cycle in which `preset_n` was sampled low (outside a save), `restore_load` is 1, `restore_val` is midscale and `rdy` is 0. After `preset_n` returns high, the wiper is reloaded from slot 0 after LOAD_CYCLES cycles.
- R8: With `wp_n` low, both save opcodes are ignored: `rdy` stays high, the store does not change and `drop_err` is not set. A restore still works as in R5.
- R9: A no-operation command (`cmd_op` = 2'b00) leaves `rdy` high, the store unchanged and produces no restore strobe.
- R10: If `preset_n` goes low during a save, the save still completes into the store before the midscale hold of R7 begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| cmd_stb | input | 1 | One-cycle strobe of a decoded command |
| cmd_op | input | 2 | Opcode: 00 nop, 01 restore, 10 save wiper, 11 save word |
| cmd_addr | input | ADDR_W | Store slot for a save-word command |
| cmd_data | input | WIPER_W | Data for a save-word command |
| wiper_now | input | WIPER_W | Present working wiper value |
| wp_n | input | 1 | Write protect, active low |
| preset_n | input | 1 | Hardware preset, active low, synchronous to clk |
| rdy | output | 1 | High when idle and able to accept a command |
| lock | output | 1 | Locks the serial front end while an operation runs |
| restore_val | output | WIPER_W | Value to load into the working wiper |
| restore_load | output | 1 | Load strobe for restore_val |
| store_flat | output | SLOTS*WIPER_W | Store contents, slot i at bits [i*WIPER_W +: WIPER_W] |
| drop_err | output | 1 | Sticky flag: a command was dropped while busy |

## Verification
The assertions assume that `preset_n` and `wp_n` are already synchronous to `clk` and that `cmd_stb` is a single-cycle pulse whose opcode and operands are valid in that cycle. The bench changes every input only at the falling clock edge and holds each strobe for exactly one cycle. It deliberately issues commands while the block is busy and while the preset pin is low, so that the drop path is exercised under those same input assumptions.

// File: rtl/nvk_pkg.sv
// Package: shared opcode and state encodings for the wiper save/restore sequencer.
// Assumes: opcodes arrive already decoded from the serial front end.
package nvk_pkg;

    typedef enum logic [1:0] {
        OP_NOP        = 2'b00,
        OP_RESTORE    = 2'b01,
        OP_SAVE_WIPER = 2'b10,
        OP_SAVE_WORD  = 2'b11
    } nvk_op_e;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'b00,
        ST_IDLE   = 2'b01,
        ST_SAVE   = 2'b10,
        ST_PRESET = 2'b11
    } nvk_state_e;

endpackage

// File: rtl/nvk_delay.sv
// Module: shared countdown timer for store programming and store read delays.
// Assumes: SAVE_CYCLES and LOAD_CYCLES are at least 1; only one start pulse per cycle.
// A start loads N-1, so done is seen in the N-th cycle after the start edge.
// Reset loads the read delay, which times the power-on restore.
module nvk_delay #(
    parameter int SAVE_CYCLES = 40,
    parameter int LOAD_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_save,
    input  logic start_load,
    output logic done
);
    localparam int MAXC = (SAVE_CYCLES > LOAD_CYCLES) ? SAVE_CYCLES : LOAD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SAVE_INIT = CW'(SAVE_CYCLES - 1);
    localparam logic [CW-1:0] LOAD_INIT = CW'(LOAD_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Purpose: load the chosen delay on a start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= LOAD_INIT;
        end else if (start_save) begin
            cnt <= SAVE_INIT;
        end else if (start_load) begin
            cnt <= LOAD_INIT;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Purpose: flag expiry of the running delay.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/nvk_cells.sv
// Module: modeled nonvolatile store, one register word per slot.
// Assumes: reset stands for first power-up of an erased part, so every slot holds midscale.
// A write whose index names no slot is discarded.
module nvk_cells #(
    parameter int WIPER_W = 10,
    parameter int SLOTS   = 4,
    parameter int ADDR_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_idx,
    input  logic [WIPER_W-1:0]       wr_data,
    output logic [SLOTS*WIPER_W-1:0] cells_flat,
    output logic [WIPER_W-1:0]       slot0
);
    localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [WIPER_W-1:0] word_q;

        // Purpose: hold one stored word, factory value midscale, written on a matching index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= MID;
            end else if (wr_en && (wr_idx == ADDR_W'(i))) begin
                word_q <= wr_data;
            end
        end

        assign cells_flat[i*WIPER_W +: WIPER_W] = word_q;
    end

    // Purpose: expose the wiper preset slot for restores.
    always_comb slot0 = cells_flat[WIPER_W-1:0];

endmodule

// File: rtl/nvk_seq.sv
// Module: control sequencer for power-on restore, restore, save, save-word and preset.
// Assumes: cmd_stb is a one-cycle pulse; preset_n and wp_n are synchronous to clk.
// Registered restore outputs; ready is high only in the idle state.
module nvk_seq
    import nvk_pkg::*;
#(
    parameter int WIPER_W = 10,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_stb,
    input  logic [1:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [WIPER_W-1:0] cmd_data,
    input  logic [WIPER_W-1:0] wiper_now,
    input  logic               wp_n,
    input  logic               preset_n,
    input  logic               timer_done,
    input  logic [WIPER_W-1:0] slot0,
    output logic               start_save,
    output logic               start_load,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_idx,
    output logic [WIPER_W-1:0] wr_data,
    output logic               ready,
    output logic               load_q,
    output logic [WIPER_W-1:0] val_q,
    output logic               err_q
);
    localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

    nvk_state_e         state, state_nxt;
    nvk_op_e            op;
    logic [ADDR_W-1:0]  pend_idx;
    logic [WIPER_W-1:0] pend_data;
    logic               take_save;
    logic               load_nxt;
    logic [WIPER_W-1:0] val_nxt;
    logic               drop;
    logic               armed;

    // Purpose: view the opcode as its enumerated meaning.
    always_comb op = nvk_op_e'(cmd_op);

    // Purpose: next state, timer starts, store write and next restore outputs.
    always_comb begin
        state_nxt  = state;
        start_save = 1'b0;
        start_load = 1'b0;
        wr_en      = 1'b0;
        take_save  = 1'b0;
        load_nxt   = 1'b0;
        val_nxt    = val_q;
        unique case (state)
            ST_LOAD: begin
                if (!preset_n) begin
                    state_nxt = ST_PRESET;
                    load_nxt  = 1'b1;
                    val_nxt   = MID;
                end else if (timer_done) begin
                    state_nxt = ST_IDLE;
                    load_nxt  = 1'b1;
                    val_nxt   = slot0;
                end
            end
            ST_IDLE: begin
                if (!preset_n) begin
                    state_nxt = ST_PRESET;
                    load_nxt  = 1'b1;
                    val_nxt   = MID;
                end else if (cmd_stb) begin
                    unique case (op)
                        OP_RESTORE: begin
                            state_nxt  = ST_LOAD;
                            start_load = 1'b1;
                        end
                        OP_SAVE_WIPER, OP_SAVE_WORD: begin
                            if (wp_n) begin
                                state_nxt  = ST_SAVE;
                                start_save = 1'b1;
                                take_save  = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_SAVE: begin
                if (timer_done) begin
                    wr_en = 1'b1;
                    if (preset_n) begin
                        state_nxt = ST_IDLE;
                    end else begin
                        state_nxt = ST_PRESET;
                        load_nxt  = 1'b1;
                        val_nxt   = MID;
                    end
                end
            end
            ST_PRESET: begin
                if (preset_n) begin
                    state_nxt  = ST_LOAD;
                    start_load = 1'b1;
                end else begin
                    load_nxt = 1'b1;
                    val_nxt  = MID;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Purpose: a strobe outside an idle, preset-free cycle is dropped.
    always_comb drop = cmd_stb && ((state != ST_IDLE) || !preset_n);

    // Purpose: state register and registered restore outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_LOAD;
            load_q <= 1'b0;
            val_q  <= MID;
        end else begin
            state  <= state_nxt;
            load_q <= load_nxt;
            val_q  <= val_nxt;
        end
    end

    // Purpose: capture the word and slot of an accepted save until programming ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (take_save) begin
            pend_idx  <= (op == OP_SAVE_WORD) ? cmd_addr : '0;
            pend_data <= (op == OP_SAVE_WORD) ? cmd_data : wiper_now;
        end
    end

    // Purpose: sticky record of dropped commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (drop) begin
            err_q <= 1'b1;
        end
    end

    // Purpose: mark that one clock has passed since reset, for $past-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        wr_idx  = pend_idx;
        wr_data = pend_data;
        ready   = (state == ST_IDLE);
    end

    // R7: a low preset outside a save drives midscale in the following cycle.
    assert_preset_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!preset_n) && $past(state != ST_SAVE) |-> load_q && (val_q == MID) && !ready);

    // R6: the drop flag never clears without reset.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R8: write protect keeps a save from starting.
    assert_wp_blocks_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cmd_stb && preset_n && !wp_n && cmd_op[1] |=> ready);

    // R5: an accepted restore leaves idle.
    assert_restore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready && cmd_stb && preset_n && (cmd_op == 2'b01) |=> !ready && !load_q);

endmodule

// File: rtl/nv_wiper_keeper.sv
// Module: top of the wiper save/restore sequencer.
// Wires the sequencer, the shared delay timer and the modeled store together.
// Assumes: all inputs synchronous to clk; SAVE_CYCLES, LOAD_CYCLES >= 1.
module nv_wiper_keeper #(
    parameter int WIPER_W     = 10,
    parameter int SLOTS       = 4,
    parameter int SAVE_CYCLES = 40,
    parameter int LOAD_CYCLES = 6,
    parameter int ADDR_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_stb,
    input  logic [1:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [WIPER_W-1:0]       cmd_data,
    input  logic [WIPER_W-1:0]       wiper_now,
    input  logic                     wp_n,
    input  logic                     preset_n,
    output logic                     rdy,
    output logic                     lock,
    output logic [WIPER_W-1:0]       restore_val,
    output logic                     restore_load,
    output logic [SLOTS*WIPER_W-1:0] store_flat,
    output logic                     drop_err
);
    logic               start_save, start_load, timer_done;
    logic               wr_en;
    logic [ADDR_W-1:0]  wr_idx;
    logic [WIPER_W-1:0] wr_data;
    logic [WIPER_W-1:0] slot0;
    logic               ready;
    logic               armed_top;

    nvk_delay #(
        .SAVE_CYCLES (SAVE_CYCLES),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_save (start_save),
        .start_load (start_load),
        .done       (timer_done)
    );

    nvk_cells #(
        .WIPER_W (WIPER_W),
        .SLOTS   (SLOTS),
        .ADDR_W  (ADDR_W)
    ) u_cells (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .cells_flat (store_flat),
        .slot0      (slot0)
    );

    nvk_seq #(
        .WIPER_W (WIPER_W),
        .ADDR_W  (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb    (cmd_stb),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .wiper_now  (wiper_now),
        .wp_n       (wp_n),
        .preset_n   (preset_n),
        .timer_done (timer_done),
        .slot0      (slot0),
        .start_save (start_save),
        .start_load (start_load),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .ready      (ready),
        .load_q     (restore_load),
        .val_q      (restore_val),
        .err_q      (drop_err)
    );

    // Purpose: drive the handshake pins from the sequencer idle indication.
    always_comb begin
        rdy  = ready;
        lock = !ready;
    end

    // Purpose: one-cycle-after-reset marker for the store checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_top <= 1'b0;
        else        armed_top <= 1'b1;
    end

    // R3: the store only changes at the end of a locked save.
    assert_store_only_saved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_top && !$stable(store_flat) |-> $past(lock) && rdy == $past(preset_n));

    // R6: a strobe while locked raises the drop flag.
    assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock && cmd_stb |=> drop_err);

    // R9: a no-operation command keeps the block idle without a load.
    assert_nop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && cmd_stb && preset_n && (cmd_op == 2'b00) |=> rdy && !restore_load);

endmodule

// File: tb/tb_nv_wiper_keeper.sv
module tb_nv_wiper_keeper;
    localparam int W     = 10;
    localparam int SLOTS = 4;
    localparam int SC    = 40;
    localparam int LC    = 6;
    localparam int AW    = 2;
    localparam logic [W-1:0] MID = 10'd512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_stb = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [W-1:0] cmd_data = '0;
    logic [W-1:0] wiper_now = '0;
    logic wp_n = 1'b1;
    logic preset_n = 1'b1;
    logic rdy, lock, restore_load, drop_err;
    logic [W-1:0] restore_val;
    logic [SLOTS*W-1:0] store_flat;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [W-1:0] model [SLOTS];
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    nv_wiper_keeper #(.WIPER_W(W), .SLOTS(SLOTS), .SAVE_CYCLES(SC), .LOAD_CYCLES(LC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .wiper_now(wiper_now), .wp_n(wp_n), .preset_n(preset_n),
        .rdy(rdy), .lock(lock), .restore_val(restore_val), .restore_load(restore_load),
        .store_flat(store_flat), .drop_err(drop_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Scoreboard monitor: every completed restore (load with rdy high) pops one expected value.
    always @(negedge clk) begin
        if (rst_n && restore_load && rdy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected restore strobe", int'(restore_val), 0);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(restore_val == e, t, int'(restore_val), int'(e));
            end
        end
    end

    task automatic expect_load(input logic [W-1:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [W-1:0] d);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rdy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic chk_store(input string t);
        for (int i = 0; i < SLOTS; i++) begin
            chk(store_flat[i*W +: W] == model[i], t, int'(store_flat[i*W +: W]), int'(model[i]));
        end
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        for (int i = 0; i < SLOTS; i++) model[i] = MID;
        repeat (3) @(negedge clk);
        // R1 / R2: reset state
        chk(rdy == 1'b0 && lock == 1'b1, "R1 reset ready/lock", int'({rdy, lock}), 1);
        chk_store("R2 factory midscale");
        expect_load(MID, "R1 power-on restore value");
        rst_n = 1'b1;
        wait_ready(n);
        chk(n == LC, "R1 power-on restore delay", n, LC);
        @(negedge clk);

        // R9: nop
        issue(2'b00, 0, 0);
        chk(rdy == 1'b1, "R9 nop keeps ready", int'(rdy), 1);
        @(negedge clk);
        chk_store("R9 nop store unchanged");

        // R3: save wiper
        wiper_now = 10'h155;
        issue(2'b10, 0, 0);
        wiper_now = 10'h2A2;
        wait_ready(n);
        chk(n == SC, "R3 save busy time", n, SC);
        model[0] = 10'h155;
        chk_store("R3 save wiper store");

        // R4: save word
        issue(2'b11, 2'd2, 10'h3FF);
        wait_ready(n);
        chk(n == SC, "R4 save word busy time", n, SC);
        model[2] = 10'h3FF;
        chk_store("R4 save word store");

        // R5: restore
        expect_load(10'h155, "R5 restore value");
        issue(2'b01, 0, 0);
        wait_ready(n);
        chk(n == LC, "R5 restore delay", n, LC);
        @(negedge clk);

        // R8: write protect
        wp_n = 1'b0;
        wiper_now = 10'h011;
        issue(2'b10, 0, 0);
        chk(rdy == 1'b1, "R8 protected save ignored (ready)", int'(rdy), 1);
        issue(2'b11, 2'd1, 10'h077);
        chk(rdy == 1'b1, "R8 protected word ignored (ready)", int'(rdy), 1);
        repeat (SC + 2) @(negedge clk);
        chk_store("R8 protected store unchanged");
        chk(drop_err == 1'b0, "R8 no drop flag", int'(drop_err), 0);
        expect_load(10'h155, "R8 restore under protect");
        issue(2'b01, 0, 0);
        wait_ready(n);
        chk(n == LC, "R8 restore delay under protect", n, LC);
        wp_n = 1'b1;
        @(negedge clk);

        // R6: command while busy
        wiper_now = 10'h0AA;
        issue(2'b10, 0, 0);
        issue(2'b11, 2'd1, 10'h123);
        chk(drop_err == 1'b1, "R6 drop flag set", int'(drop_err), 1);
        wait_ready(n);
        model[0] = 10'h0AA;
        chk_store("R6 dropped word not written");
        @(negedge clk);

        // R7: preset pin
        preset_n = 1'b0;
        issue(2'b01, 0, 0);
        for (int k = 0; k < 3; k++) begin
            chk(restore_load && restore_val == MID && !rdy, "R7 preset midscale hold",
                int'(restore_val), int'(MID));
            @(negedge clk);
        end
        preset_n = 1'b1;
        expect_load(10'h0AA, "R7 reload after preset");
        @(negedge clk);
        wait_ready(n);
        chk(n == LC, "R7 reload delay", n, LC);
        @(negedge clk);

        // R10: preset during save
        wiper_now = 10'h001;
        issue(2'b10, 0, 0);
        preset_n = 1'b0;
        repeat (SC + 4) @(negedge clk);
        model[0] = 10'h001;
        chk_store("R10 save completes under preset");
        chk(restore_load && restore_val == MID && !rdy, "R10 midscale after save",
            int'(restore_val), int'(MID));
        preset_n = 1'b1;
        expect_load(10'h001, "R10 reload of saved value");
        @(negedge clk);
        wait_ready(n);
        chk(n == LC, "R10 reload delay", n, LC);
        repeat (2) @(negedge clk);

        chk(drop_err == 1'b1, "R6 drop flag still set", int'(drop_err), 1);
        chk(exp_q.size() == 0, "R5 all expected restores seen", exp_q.size(), 0);
        finish_run();
    end
endmodule